// File: doc/BRIEF.md
# Deep Power-Down Wake Controller

This block sequences a processor subsystem into and out of its deepest power-down state. Software first sets an enable bit. The processor then issues a wait-for-interrupt or wait-for-event strobe. If no debugger is attached at that moment, the controller raises a request that tells the power switches to remove the supply from the logic domain. The controller itself sits in the always-on domain.

While powered down, the controller watches three wake sources:
- a falling edge on an external wake pin, which passes through a synchronizer;
- a wake timer that counts ticks of a low-frequency oscillator up to a count chosen by a select field;
- a power-on-reset event.

Each source has its own sticky flag, which software clears by writing 1. A disable bit with inverted sense can mask the pin. A second bit stops the oscillator during power-down, which makes a timed wake impossible. On a wake the controller drops the power-down request and pulses a one-cycle reset to the processor, so that the processor boots from its reset vector. The flags tell software what woke it. An 8-bit scratch register keeps one byte of software state across the whole sequence.

Top module: `dpd_wake_ctrl`

## Requirements
- R1: After reset, `pd_req_o` and `cpu_rst_o` are 0, `flags_o` is 3'b000 and `scratch_o` is 0.
- R2: When the block is running and a clock edge samples `dpd_en_i`=1, `wfi_i`=1 and `dbg_active_i`=0 together, `pd_req_o` is 1 from that edge on.
- R3: While running, a `wfi_i` strobe does not raise `pd_req_o` if `dbg_active_i` is 1 or if `dpd_en_i` is 0 at that edge.
- R4: While powered down with `pin_wake_dis_i`=0, a high-to-low change on `wake_pin_i` causes a wake. Counting the first clock edge that samples the pin low as edge 1, the wake happens at edge 3, after two synchronizer stages and one edge-detect stage. The wake sets `flags_o[0]`.
- R5: With `pin_wake_dis_i`=1 the wake pin causes no wake and leaves `flags_o[0]` unchanged.
- R6: The wake counter is cleared on entry and counts `lfo_tick_i` strobes while powered down. With `TBASE_LOG`=2, bit k of `tmr_sel_i` selects a wake after 2^(2+k) ticks. The wake happens at the edge after the tick that reaches the count. When several bits are set, the smallest selected count wins. With no bit set there is no timed wake. A timed wake sets `flags_o[1]`.
- R7: While `lfo_pd_i` is 1, ticks are not counted and no timed wake happens.
- R8: While powered down, `por_evt_i`=1 at a clock edge causes a wake at that edge and sets `flags_o[2]`.
- R9: At the wake edge `pd_req_o` falls and `cpu_rst_o` rises. `cpu_rst_o` stays high for exactly one cycle and is never high at any other time.
- R10: The flags are sticky. Writing a 1 to a bit of `flag_clr_i` clears the matching flag. A flag that is set and cleared at the same edge ends up set. Sources that fire at the same wake edge all set their flags.
- R11: `scratch_o` changes only when `scratch_we_i` writes it. It keeps its value through power-down and wake.
- R12: While the block is running, a wake-pin edge or a `por_evt_i` pulse sets no flag and produces no `cpu_rst_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dpd_en_i | input | 1 | Software enable for power-down entry |
| wfi_i | input | 1 | Wait-for-interrupt/event strobe from the processor |
| dbg_active_i | input | 1 | Debug interface active; blocks entry |
| wake_pin_i | input | 1 | Asynchronous external wake pin, idle high |
| pin_wake_dis_i | input | 1 | 1 masks the wake pin |
| lfo_tick_i | input | 1 | One-cycle strobe per low-frequency oscillator period |
| lfo_pd_i | input | 1 | 1 stops the oscillator in power-down (no timed wake) |
| tmr_sel_i | input | TSEL_W | Wake count select, bit k = 2^(TBASE_LOG+k) ticks |
| por_evt_i | input | 1 | Power-on-reset event from the supply monitor |
| flag_clr_i | input | 3 | Write-1-to-clear strobes for the wake flags |
| scratch_we_i | input | 1 | Scratch register write enable |
| scratch_wdata_i | input | SCR_W | Scratch register write data |
| pd_req_o | output | 1 | Power-down request for the logic domain |
| cpu_rst_o | output | 1 | One-cycle processor reset pulse on wake |
| flags_o | output | 3 | Wake flags: [0] pin, [1] timer, [2] power-on reset |
| scratch_o | output | SCR_W | Scratch register contents |

## Verification
The bench checks the pin path's exact latency. A design with one synchronizer stage too few or too many, or one that detects the rising edge, would wake a cycle off or at the wrong moment. It also checks the timer at both ends of the selected count, so an off-by-one compare or a counter that is not cleared on entry shows up as an early or late wake. When two select bits are set, a design that uses the largest count instead of the smallest would wake late. Other corner cases are a pin edge and a power-on event at the same edge with a clear strobe pending, where a design that lets the clear win or that latches only one source would lose a flag. The bench also drives wake stimulus while the block is running and while it is masked, and a design that leaks it would show spurious flags or reset pulses.

// File: rtl/dpd_wake_pkg.sv
package dpd_wake_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_DOWN = 1'b1
  } pwr_state_e;

  localparam int unsigned SRC_PIN = 0;
  localparam int unsigned SRC_TMR = 1;
  localparam int unsigned SRC_POR = 2;
  localparam int unsigned SRC_NUM = 3;

  // Bit order matches the flag vector: [2] por, [1] timer, [0] pin.
  typedef struct packed {
    logic por;
    logic tmr;
    logic pin;
  } wake_src_t;

endpackage

// File: rtl/dpd_pin_sync.sv
module dpd_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              hist_q;
  logic              hist_d;

  // Shift chain: bit 0 samples the pin, the top bit is the settled value.
  always_comb begin
    chain_d = {chain_q[STAGES-2:0], pin_i};
    hist_d  = chain_q[STAGES-1];
  end

  // Reset to the idle-high level so release of reset is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      hist_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      hist_q  <= hist_d;
    end
  end

  assign fall_o = hist_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/dpd_wake_timer.sv
module dpd_wake_timer #(
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned BASE_LOG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             hit_o
);

  localparam int unsigned         CNT_W   = BASE_LOG + SEL_W;
  localparam logic [CNT_W-1:0]    CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic [SEL_W-1:0] tap_match;

  // Clear while running; count ticks while down, saturating at the top.
  always_comb begin
    cnt_en = clr_i | (run_i & tick_i & (cnt_q != CNT_MAX));
    cnt_d  = clr_i ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // One comparator per select bit; each tap is a distinct power of two.
  for (genvar k = 0; k < SEL_W; k++) begin : g_tap
    localparam logic [CNT_W-1:0] TAP = CNT_W'(1) << (BASE_LOG + k);
    assign tap_match[k] = sel_i[k] & (cnt_q == TAP);
  end

  assign hit_o = run_i & (|tap_match);

endmodule

// File: rtl/dpd_flag_bank.sv
module dpd_flag_bank #(
  parameter int unsigned NSRC  = 3,
  parameter int unsigned SCR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  set_i,
  input  logic [NSRC-1:0]  clr_i,
  input  logic             scr_we_i,
  input  logic [SCR_W-1:0] scr_wdata_i,
  output logic [NSRC-1:0]  flags_o,
  output logic [SCR_W-1:0] scr_o
);

  logic [NSRC-1:0]  flags_q;
  logic [NSRC-1:0]  flags_d;
  logic             flags_en;
  logic [SCR_W-1:0] scr_q;

  // Set dominates clear on the same edge.
  always_comb begin
    flags_en = (|set_i) | (|clr_i);
    flags_d  = (flags_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scr_q <= '0;
    end else if (scr_we_i) begin
      scr_q <= scr_wdata_i;
    end
  end

  assign flags_o = flags_q;
  assign scr_o   = scr_q;

endmodule

// File: rtl/dpd_wake_ctrl.sv
module dpd_wake_ctrl
  import dpd_wake_pkg::*;
#(
  parameter int unsigned TSEL_W      = 4,
  parameter int unsigned TBASE_LOG   = 2,
  parameter int unsigned SCR_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dpd_en_i,
  input  logic              wfi_i,
  input  logic              dbg_active_i,
  input  logic              wake_pin_i,
  input  logic              pin_wake_dis_i,
  input  logic              lfo_tick_i,
  input  logic              lfo_pd_i,
  input  logic [TSEL_W-1:0] tmr_sel_i,
  input  logic              por_evt_i,
  input  logic [2:0]        flag_clr_i,
  input  logic              scratch_we_i,
  input  logic [SCR_W-1:0]  scratch_wdata_i,
  output logic              pd_req_o,
  output logic              cpu_rst_o,
  output logic [2:0]        flags_o,
  output logic [SCR_W-1:0]  scratch_o
);

  pwr_state_e         state_q;
  pwr_state_e         state_d;
  logic               rst_pulse_q;
  logic               rst_pulse_d;
  logic               pin_fall;
  logic               tmr_hit;
  logic               tmr_run;
  logic               tmr_clr;
  logic               enter_req;
  logic               wake_any;
  wake_src_t          src;
  logic [SRC_NUM-1:0] flag_set;

  dpd_pin_sync #(
    .STAGES (SYNC_STAGES)
  ) u_pin_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (wake_pin_i),
    .fall_o (pin_fall)
  );

  assign tmr_clr = (state_q == ST_RUN);
  assign tmr_run = (state_q == ST_DOWN) & ~lfo_pd_i;

  dpd_wake_timer #(
    .SEL_W    (TSEL_W),
    .BASE_LOG (TBASE_LOG)
  ) u_wake_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (tmr_clr),
    .run_i  (tmr_run),
    .tick_i (lfo_tick_i),
    .sel_i  (tmr_sel_i),
    .hit_o  (tmr_hit)
  );

  // Wake source qualification and entry condition.
  always_comb begin
    src.pin   = pin_fall & ~pin_wake_dis_i;
    src.tmr   = tmr_hit;
    src.por   = por_evt_i;
    enter_req = (state_q == ST_RUN) & dpd_en_i & wfi_i & ~dbg_active_i;
    wake_any  = (state_q == ST_DOWN) & (|src);
    flag_set  = wake_any ? src : '0;
  end

  // Next-state logic.
  always_comb begin
    state_d     = state_q;
    rst_pulse_d = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (enter_req) begin
          state_d = ST_DOWN;
        end
      end
      ST_DOWN: begin
        if (wake_any) begin
          state_d     = ST_RUN;
          rst_pulse_d = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_RUN;
      rst_pulse_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      rst_pulse_q <= rst_pulse_d;
    end
  end

  dpd_flag_bank #(
    .NSRC  (SRC_NUM),
    .SCR_W (SCR_W)
  ) u_flag_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (flag_set),
    .clr_i       (flag_clr_i),
    .scr_we_i    (scratch_we_i),
    .scr_wdata_i (scratch_wdata_i),
    .flags_o     (flags_o),
    .scr_o       (scratch_o)
  );

  assign pd_req_o  = (state_q == ST_DOWN);
  assign cpu_rst_o = rst_pulse_q;

endmodule

// File: rtl/dpd_wake_ctrl_chk.sv
module dpd_wake_ctrl_chk #(
  parameter int unsigned SCR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dpd_en_i,
  input logic             wfi_i,
  input logic             dbg_active_i,
  input logic             pin_wake_dis_i,
  input logic             lfo_pd_i,
  input logic             scratch_we_i,
  input logic             pd_req_o,
  input logic             cpu_rst_o,
  input logic [2:0]       flags_o,
  input logic [SCR_W-1:0] scratch_o
);

  // R2
  entry_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_req_o && dpd_en_i && wfi_i && !dbg_active_i) |=> pd_req_o);

  // R3
  entry_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_req_o && (dbg_active_i || !dpd_en_i)) |=> !pd_req_o);

  // R9
  wake_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_req_o) |-> cpu_rst_o);

  // R9
  reset_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_o |=> !cpu_rst_o);

  // R9
  reset_only_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_o |-> $fell(pd_req_o));

  // R5
  pin_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_req_o && pin_wake_dis_i) |=> !$rose(flags_o[0]));

  // R7
  timer_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_req_o && lfo_pd_i) |=> !$rose(flags_o[1]));

  // R12
  run_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_req_o |=> ((flags_o & ~$past(flags_o)) == 3'b000));

  // R11
  scratch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scratch_we_i |=> $stable(scratch_o));

endmodule

bind dpd_wake_ctrl dpd_wake_ctrl_chk #(
  .SCR_W (SCR_W)
) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .dpd_en_i       (dpd_en_i),
  .wfi_i          (wfi_i),
  .dbg_active_i   (dbg_active_i),
  .pin_wake_dis_i (pin_wake_dis_i),
  .lfo_pd_i       (lfo_pd_i),
  .scratch_we_i   (scratch_we_i),
  .pd_req_o       (pd_req_o),
  .cpu_rst_o      (cpu_rst_o),
  .flags_o        (flags_o),
  .scratch_o      (scratch_o)
);

// File: tb/test_dpd_wake_ctrl.sv
`timescale 1ns/1ps
module test_dpd_wake_ctrl;

  localparam int TSEL_W    = 4;
  localparam int TBASE_LOG = 2;
  localparam int SCR_W     = 8;
  localparam int TMAX      = (1 << (TBASE_LOG + TSEL_W)) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              dpd_en = 1'b0;
  logic              wfi = 1'b0;
  logic              dbg = 1'b0;
  logic              wake_pin = 1'b1;
  logic              pin_dis = 1'b0;
  logic              lfo_tick = 1'b0;
  logic              lfo_pd = 1'b0;
  logic [TSEL_W-1:0] tsel = '0;
  logic              por = 1'b0;
  logic [2:0]        fclr = 3'b000;
  logic              swe = 1'b0;
  logic [SCR_W-1:0]  swdata = '0;
  logic              pd_req;
  logic              cpu_rst;
  logic [2:0]        flags;
  logic [SCR_W-1:0]  scratch;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dpd_wake_ctrl #(
    .TSEL_W (TSEL_W), .TBASE_LOG (TBASE_LOG), .SCR_W (SCR_W), .SYNC_STAGES (2)
  ) i_dpd_wake_ctrl (
    .clk (clk), .rst_n (rst_n), .dpd_en_i (dpd_en), .wfi_i (wfi),
    .dbg_active_i (dbg), .wake_pin_i (wake_pin), .pin_wake_dis_i (pin_dis),
    .lfo_tick_i (lfo_tick), .lfo_pd_i (lfo_pd), .tmr_sel_i (tsel),
    .por_evt_i (por), .flag_clr_i (fclr), .scratch_we_i (swe),
    .scratch_wdata_i (swdata), .pd_req_o (pd_req), .cpu_rst_o (cpu_rst),
    .flags_o (flags), .scratch_o (scratch)
  );

  // Behavioural reference model, advanced on each rising edge.
  bit             m_down;
  int             m_ticks;
  bit             m_rst;
  bit [2:0]       m_flags;
  bit [SCR_W-1:0] m_scr;
  bit             pin_q[$];

  always @(posedge clk or negedge rst_n) begin
    bit fall, thit, wake;
    bit [2:0] setv;
    if (!rst_n) begin
      m_down = 0; m_ticks = 0; m_rst = 0; m_flags = 0; m_scr = 0;
      pin_q = {1'b1, 1'b1, 1'b1};
    end else begin
      fall = pin_q[2] && !pin_q[1];
      thit = 0;
      if (m_down && !lfo_pd)
        for (int k = 0; k < TSEL_W; k++)
          if (tsel[k] && m_ticks == (1 << (TBASE_LOG + k))) thit = 1;
      wake = m_down && ((fall && !pin_dis) || thit || por);
      setv = wake ? {por, thit, fall && !pin_dis} : 3'b000;
      m_flags = (m_flags & ~fclr) | setv;
      if (swe) m_scr = swdata;
      m_rst = wake;
      if (!m_down) m_ticks = 0;
      else if (lfo_tick && !lfo_pd && m_ticks < TMAX) m_ticks++;
      if (!m_down && dpd_en && wfi && !dbg) m_down = 1;
      else if (wake) m_down = 0;
      pin_q.push_front(wake_pin);
      void'(pin_q.pop_back());
    end
  end

  // Compare every cycle away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks += 4;
      if (pd_req !== m_down) begin
        errors++; $display("FAIL R2 pd_req actual=%0b expected=%0b t=%0t", pd_req, m_down, $time);
      end
      if (cpu_rst !== m_rst) begin
        errors++; $display("FAIL R9 cpu_rst actual=%0b expected=%0b t=%0t", cpu_rst, m_rst, $time);
      end
      if (flags !== m_flags) begin
        errors++; $display("FAIL R10 flags actual=%b expected=%b t=%0t", flags, m_flags, $time);
      end
      if (scratch !== m_scr) begin
        errors++; $display("FAIL R11 scratch actual=%h expected=%h t=%0t", scratch, m_scr, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_wfi();
    wfi = 1'b1; cyc(1); wfi = 1'b0; cyc(1);
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      lfo_tick = 1'b1; cyc(1); lfo_tick = 1'b0; cyc(gap);
    end
  endtask

  task automatic clear_all();
    fclr = 3'b111; cyc(1); fclr = 3'b000; cyc(1);
  endtask

  task automatic por_wake();
    por = 1'b1; cyc(1); por = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 pd_req", pd_req, 0);
    chk("R1 cpu_rst", cpu_rst, 0);
    chk("R1 flags", flags, 0);
    chk("R1 scratch", scratch, 0);

    swe = 1'b1; swdata = 8'h5A; cyc(1); swe = 1'b0; cyc(1);

    // R3 entry blocked by debug or by missing enable
    dpd_en = 1'b1; dbg = 1'b1; strobe_wfi(); cyc(2);
    chk("R3 dbg blocks", pd_req, 0);
    dbg = 1'b0; dpd_en = 1'b0; strobe_wfi(); cyc(2);
    chk("R3 enable off", pd_req, 0);

    // R2 entry, R4 pin wake with exact latency
    dpd_en = 1'b1; strobe_wfi();
    chk("R2 entered", pd_req, 1);
    wake_pin = 1'b0; cyc(2);
    chk("R4 still down", pd_req, 1);
    cyc(1);
    chk("R4 woke", pd_req, 0);
    chk("R9 reset pulse", cpu_rst, 1);
    chk("R4 pin flag", flags, 3'b001);
    cyc(1);
    chk("R9 pulse ended", cpu_rst, 0);
    chk("R11 scratch kept", scratch, 8'h5A);
    wake_pin = 1'b1; cyc(4);

    // R10 write-1-to-clear
    fclr = 3'b001; cyc(1); fclr = 3'b000; cyc(1);
    chk("R10 cleared", flags, 0);

    // R5 masked pin, then R8 por wake
    pin_dis = 1'b1; strobe_wfi();
    wake_pin = 1'b0; cyc(6);
    chk("R5 pin ignored", pd_req, 1);
    chk("R5 no flag", flags, 0);
    wake_pin = 1'b1; cyc(2);
    por_wake();
    chk("R8 por woke", pd_req, 0);
    chk("R8 por flag", flags, 3'b100);
    pin_dis = 1'b0; cyc(2); clear_all();

    // R6 timer with single select bit: bit 2 -> 16 ticks
    tsel = 4'b0100; strobe_wfi();
    ticks(15, 2);
    chk("R6 not yet", pd_req, 1);
    lfo_tick = 1'b1; cyc(1); lfo_tick = 1'b0;
    chk("R6 count reached", pd_req, 1);
    cyc(1);
    chk("R6 timed wake", pd_req, 0);
    chk("R6 timer flag", flags, 3'b010);
    cyc(2); clear_all();

    // R6 two select bits: bits 1,2 -> smallest count 8
    tsel = 4'b0110; strobe_wfi();
    ticks(7, 1);
    chk("R6 smallest not yet", pd_req, 1);
    ticks(1, 1);
    chk("R6 smallest wins", pd_req, 0);
    cyc(2); clear_all();

    // R6 no select bit: no timed wake
    tsel = 4'b0000; strobe_wfi();
    ticks(70, 0);
    chk("R6 no select", pd_req, 1);
    por_wake(); cyc(2); clear_all();

    // R7 oscillator stopped
    tsel = 4'b0001; lfo_pd = 1'b1; strobe_wfi();
    ticks(10, 1);
    chk("R7 no timed wake", pd_req, 1);
    chk("R7 no timer flag", flags, 0);
    por_wake(); lfo_pd = 1'b0; tsel = '0; cyc(2); clear_all();

    // R10 simultaneous sources with a clear at the same edge
    fclr = 3'b000; strobe_wfi();
    wake_pin = 1'b0; cyc(2);
    por = 1'b1; fclr = 3'b111; cyc(1); por = 1'b0; fclr = 3'b000;
    chk("R10 both set, set beats clear", flags, 3'b101);
    fclr = 3'b001; cyc(1); fclr = 3'b000; cyc(1);
    chk("R10 partial clear", flags, 3'b100);
    wake_pin = 1'b1; cyc(4); clear_all();

    // R12 wake stimulus while running
    dpd_en = 1'b0;
    por_wake(); wake_pin = 1'b0; cyc(5); wake_pin = 1'b1; cyc(5);
    chk("R12 no flags", flags, 0);
    chk("R12 no reset", cpu_rst, 0);
    chk("R11 final scratch", scratch, 8'h5A);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule